// File: doc/BRIEF.md
# Multiplexed Dual-Mode Host Bus Interface

This block lets a microprocessor reach a bank of eight byte-wide configuration registers over one shared 8-bit address/data bus. Each access begins with an address phase. The host drives the register address on the shared lines while the address latch strobe is high. The falling edge of that strobe fixes the address. A data phase follows, and one of two host conventions carries it. A static style pin selects the convention. In split-strobe style, separate active-low read and write strobes are used. In data-strobe style, one active-high data strobe is qualified by a read/write line.

All strobes are asynchronous to the block's clock. Each one passes through a two-flop synchroniser before its edges are detected. The shared data lines are delayed by the same two stages, so data stays aligned with its strobe. A write takes the byte that was present while the write strobe was active, and commits it when the strobe ends. During a read, the addressed byte goes out on a separate output together with an output-enable for the pad. The enable drops when the read strobe is released. The register contents are presented as one flat vector for the surrounding logic.

Top module: `mux_host_port`

## Requirements
- R1: Under reset (synchronous, active low), every register is 0x00, `ad_oe` is 0 and `ad_out` is 0x00.
- R2: Register k (k = 0..7) answers at address 0x2B + k, so addresses 0x2B to 0x32 are mapped. Its contents appear on `cfg_regs[8k+7:8k]`. The address used by an access is the value on `ad_in` while `ale` was high, fixed on the falling edge of `ale`.
- R3: With `bus_style` = 0 (split-strobe), the byte on `ad_in` while `wr_n` is low is written to the latched register when `wr_n` returns high.
- R4: With `bus_style` = 1 (data-strobe), the byte on `ad_in` while `ds` is high and `rw` is 0 is written to the latched register when `ds` falls.
- R5: With `bus_style` = 0, `ad_oe` is 1 and `ad_out` carries the latched register while `rd_n` is low. When `rd_n` returns high, `ad_oe` goes to 0 and `ad_out` to 0x00.
- R6: With `bus_style` = 1, `ad_oe` is 1 and `ad_out` carries the latched register while `ds` is high and `rw` is 1. When `ds` falls, `ad_oe` goes to 0 and `ad_out` to 0x00.
- R7: A read of an unmapped address drives 0x00 with `ad_oe` = 1. A write to an unmapped address changes no register.
- R8: The strobes of the style that is not selected have no effect: no register changes and `ad_oe` stays 0.
- R9: A write whose strobe ends in the same cycle that `ale` rises for the next access lands at the address latched before that rise.
- R10: Any effect of an input change becomes visible on the outputs after the third rising clock edge that follows the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_style | input | 1 | 0 = split read/write strobes, 1 = data strobe with read/write line |
| ale | input | 1 | Address latch strobe, active high; address fixed on its fall |
| ad_in | input | 8 | Shared address/data lines, as seen at the pad input |
| rd_n | input | 1 | Read strobe, active low (split-strobe style) |
| wr_n | input | 1 | Write strobe, active low (split-strobe style) |
| ds | input | 1 | Data strobe, active high (data-strobe style) |
| rw | input | 1 | 1 = read, 0 = write (data-strobe style) |
| ad_out | output | 8 | Read data for the pad driver; 0x00 when not enabled |
| ad_oe | output | 1 | Pad output-enable, high during an active read |
| cfg_regs | output | 64 | Register contents, register k in bits 8k+7:8k |

## Verification
Two things can coincide in one cycle: the end of a write strobe, which commits the data, and the rise of the address strobe that opens the next access. The bench releases `wr_n` and raises `ale` with a new address on the same clock edge. Its model places the byte at the old address. Every clock it compares the whole register vector and both read outputs, so a write that follows the new address, or one that is lost, is seen the cycle it happens. Later reads of both addresses confirm the result through the bus.

// File: rtl/hbi_pkg.sv
// Package: shared constants and the bus-style encoding for the host port.
// Assumes: one byte-wide bank at a fixed, contiguous address window.
package hbi_pkg;
    localparam int unsigned HP_BYTE_W    = 8;
    localparam int unsigned HP_BANK_SIZE = 8;
    localparam int unsigned HP_BANK_BASE = 'h2B;

    typedef enum logic {
        STYLE_SPLIT = 1'b0,   // separate active-low read and write strobes
        STYLE_DSTRB = 1'b1    // active-high data strobe plus read/write line
    } bus_style_e;
endpackage

// File: rtl/hp_sync2.sv
// Module: two-flop synchroniser for a vector of asynchronous inputs.
// Assumes: each bit is either a level signal or slow relative to clk;
// the reset value gives the idle level of each bit.
module hp_sync2 #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hp_strobe_decode.sv
// Module: turns synchronised strobes into an address latch, a write
// commit pulse with its data, and a read-active level.
// Assumes: inputs already synchronised and the shared data lines delayed
// by the same number of stages, so data aligns with its strobe.
module hp_strobe_decode
    import hbi_pkg::*;
#(
    parameter int unsigned DW = HP_BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          style,
    input  logic          ale_s,
    input  logic          rd_n_s,
    input  logic          wr_n_s,
    input  logic          ds_s,
    input  logic          rw_s,
    input  logic [DW-1:0] ad_s,
    output logic [DW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          wr_commit,
    output logic          rd_act
);
    logic          wr_act;
    logic          wr_act_d;
    logic          ale_d;
    logic [DW-1:0] addr_hold;

    // Select which strobes define the read and write windows.
    always_comb begin
        if (bus_style_e'(style) == STYLE_DSTRB) begin
            wr_act = ds_s & ~rw_s;
            rd_act = ds_s &  rw_s;
        end else begin
            wr_act = ~wr_n_s;
            rd_act = ~rd_n_s;
        end
    end

    // A write ends when its window closes.
    assign wr_commit = wr_act_d & ~wr_act;

    // Track address phase, capture address and write data while windows are open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_d     <= 1'b0;
            wr_act_d  <= 1'b0;
            addr_hold <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
        end else begin
            ale_d    <= ale_s;
            wr_act_d <= wr_act;
            if (ale_s)
                addr_hold <= ad_s;
            if (ale_d && !ale_s)
                addr_q <= addr_hold;
            if (wr_act)
                wdata_q <= ad_s;
        end
    end

    // R8
    split_ignores_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (style == 1'b0 && wr_n_s && $past(wr_n_s)) |-> !wr_commit);
endmodule

// File: rtl/hp_reg_bank.sv
// Module: bank of byte registers at a contiguous address window, with
// write enable and combinational read data (0 for unmapped addresses).
// Assumes: wr_en is a single-cycle pulse.
module hp_reg_bank
    import hbi_pkg::*;
#(
    parameter int unsigned N    = HP_BANK_SIZE,
    parameter int unsigned DW   = HP_BYTE_W,
    parameter int unsigned BASE = HP_BANK_BASE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [DW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic [N*DW-1:0] regs_flat
);
    logic [N-1:0]         hit;
    logic [N-1:0][DW-1:0] regs;

    // Per-register address decode.
    for (genvar i = 0; i < N; i++) begin : g_dec
        localparam logic [DW-1:0] REG_ADDR = DW'(BASE + i);
        assign hit[i] = (addr == REG_ADDR);
        assign regs_flat[i*DW +: DW] = regs[i];
    end

    // Register storage, written on a decoded commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < N; k++)
                if (hit[k])
                    regs[k] <= wdata;
        end
    end

    // Read mux; no hit yields zero.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < N; k++)
            if (hit[k])
                rdata = regs[k];
    end

    // R3
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));

    // R7
    unmapped_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit == '0) |=> $stable(regs_flat));
endmodule

// File: rtl/mux_host_port.sv
// Module: multiplexed address/data host port in front of a byte register
// bank, serving both split-strobe and data-strobe host conventions.
// Assumes: bus_style changes only while all strobes are idle; each bus
// phase lasts at least four clock cycles.
module mux_host_port
    import hbi_pkg::*;
#(
    parameter int unsigned NUM_REGS  = HP_BANK_SIZE,
    parameter int unsigned DATA_W    = HP_BYTE_W,
    parameter int unsigned BASE_ADDR = HP_BANK_BASE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_style,
    input  logic                     ale,
    input  logic [DATA_W-1:0]        ad_in,
    input  logic                     rd_n,
    input  logic                     wr_n,
    input  logic                     ds,
    input  logic                     rw,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
    localparam int unsigned CTL_W = 5;
    localparam logic [CTL_W-1:0] CTL_IDLE = 5'b01101; // ale,rd_n,wr_n,ds,rw

    logic [CTL_W-1:0]  ctl_s;
    logic [DATA_W-1:0] ad_s;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata;
    logic              wr_commit;
    logic              rd_act;

    hp_sync2 #(.W(CTL_W), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ale, rd_n, wr_n, ds, rw}),
        .q     (ctl_s)
    );

    hp_sync2 #(.W(DATA_W), .RST_VAL('0)) u_ad_align (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ad_in),
        .q     (ad_s)
    );

    hp_strobe_decode #(.DW(DATA_W)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .style     (bus_style),
        .ale_s     (ctl_s[4]),
        .rd_n_s    (ctl_s[3]),
        .wr_n_s    (ctl_s[2]),
        .ds_s      (ctl_s[1]),
        .rw_s      (ctl_s[0]),
        .ad_s      (ad_s),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .wr_commit (wr_commit),
        .rd_act    (rd_act)
    );

    hp_reg_bank #(.N(NUM_REGS), .DW(DATA_W), .BASE(BASE_ADDR)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_commit),
        .addr      (addr_q),
        .wdata     (wdata_q),
        .rdata     (rdata),
        .regs_flat (cfg_regs)
    );

    // Register the pad enable and read data; zero the data when released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_oe  <= 1'b0;
            ad_out <= '0;
        end else begin
            ad_oe  <= rd_act;
            ad_out <= rd_act ? rdata : '0;
        end
    end

    // R5
    oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |=> ad_oe);

    // R6
    release_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ad_oe) |-> ad_out == '0);
endmodule

// File: tb/mux_host_port_test.sv
module mux_host_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_style = 1'b0;
    logic        ale = 1'b0;
    logic [7:0]  ad_in = 8'h00;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        ds = 1'b0;
    logic        rw = 1'b1;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [63:0] cfg_regs;

    always #4 clk = ~clk; // 125 MHz

    mux_host_port uut (
        .clk(clk), .rst_n(rst_n), .bus_style(bus_style), .ale(ale),
        .ad_in(ad_in), .rd_n(rd_n), .wr_n(wr_n), .ds(ds), .rw(rw),
        .ad_out(ad_out), .ad_oe(ad_oe), .cfg_regs(cfg_regs)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string req = "R1";

    // Behavioural reference state.
    byte unsigned m_reg[8];
    byte unsigned m_addr = 0;
    logic         m_oe = 1'b0;
    byte unsigned m_dout = 0;

    function automatic byte unsigned lookup(byte unsigned a);
        if (a >= 8'h2B && a <= 8'h32) return m_reg[a - 8'h2B];
        return 8'h00;
    endfunction

    function automatic logic [63:0] model_vec();
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[k*8 +: 8] = m_reg[k];
        return v;
    endfunction

    // One clock: advance to the falling edge and compare all outputs (R10).
    task automatic step();
        @(negedge clk);
        n_chk++;
        if (cfg_regs !== model_vec() || ad_oe !== m_oe || ad_out !== m_dout) begin
            n_bad++;
            $display("FAIL %s: cfg=%h/%h oe=%b/%b out=%h/%h", req,
                     cfg_regs, model_vec(), ad_oe, m_oe, ad_out, m_dout);
        end
    endtask

    task automatic addr_phase(input byte unsigned a);
        ale = 1'b1; ad_in = a;
        repeat (4) step();
        ale = 1'b0; ad_in = 8'hA5;
        step(); step();
        m_addr = a;
        step(); step();
    endtask

    task automatic split_write(input byte unsigned a, input byte unsigned d);
        addr_phase(a);
        ad_in = d; wr_n = 1'b0;
        repeat (4) step();
        wr_n = 1'b1; ad_in = ~d;
        step(); step();
        if (a >= 8'h2B && a <= 8'h32) m_reg[a - 8'h2B] = d;
        step(); step();
    endtask

    task automatic split_read(input byte unsigned a);
        addr_phase(a);
        ad_in = 8'h5A; rd_n = 1'b0;
        step(); step();
        m_oe = 1'b1; m_dout = lookup(m_addr);
        step(); step();
        rd_n = 1'b1;
        step(); step();
        m_oe = 1'b0; m_dout = 8'h00;
        step(); step();
    endtask

    task automatic dstrb_write(input byte unsigned a, input byte unsigned d);
        addr_phase(a);
        rw = 1'b0; ad_in = d; ds = 1'b1;
        repeat (4) step();
        ds = 1'b0; ad_in = 8'h33;
        step(); step();
        if (a >= 8'h2B && a <= 8'h32) m_reg[a - 8'h2B] = d;
        step(); step();
        rw = 1'b1;
        repeat (4) step();
    endtask

    task automatic dstrb_read(input byte unsigned a);
        addr_phase(a);
        rw = 1'b1; ad_in = 8'h66; ds = 1'b1;
        step(); step();
        m_oe = 1'b1; m_dout = lookup(m_addr);
        step(); step();
        ds = 1'b0;
        step(); step();
        m_oe = 1'b0; m_dout = 8'h00;
        step(); step();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) m_reg[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        req = "R1";
        repeat (3) step();

        // R3 / R2: split-strobe writes at both ends of the window
        req = "R3";
        split_write(8'h2B, 8'h11);
        split_write(8'h32, 8'hEE);
        split_write(8'h2F, 8'h5C);
        // R5 / R2: split-strobe reads
        req = "R5";
        split_read(8'h2B);
        split_read(8'h32);
        split_read(8'h2F);
        split_read(8'h2C);

        // R7: unmapped addresses just outside and far from the window
        req = "R7";
        split_write(8'h2A, 8'h77);
        split_write(8'h33, 8'h78);
        split_write(8'h00, 8'hFF);
        split_read(8'h33);
        split_read(8'h2A);

        // R8: data-strobe activity ignored in split-strobe style
        req = "R8";
        addr_phase(8'h2D);
        rw = 1'b0; ad_in = 8'h99; ds = 1'b1;
        repeat (4) step();
        ds = 1'b0; repeat (4) step();
        rw = 1'b1; ds = 1'b1; repeat (4) step();
        ds = 1'b0; repeat (4) step();

        // R9: write end coincides with next address strobe rising
        req = "R9";
        addr_phase(8'h2E);
        ad_in = 8'hC3; wr_n = 1'b0;
        repeat (4) step();
        wr_n = 1'b1; ale = 1'b1; ad_in = 8'h30;
        step(); step();
        m_reg[8'h2E - 8'h2B] = 8'hC3;
        step(); step();
        ale = 1'b0; ad_in = 8'h01;
        step(); step();
        m_addr = 8'h30;
        step(); step();
        split_read(8'h2E);
        split_read(8'h30);

        // Switch style with all strobes idle.
        bus_style = 1'b1;
        req = "R4";
        repeat (4) step();
        dstrb_write(8'h2C, 8'hA1);
        dstrb_write(8'h31, 8'h3E);
        dstrb_write(8'h2B, 8'h00);
        req = "R6";
        dstrb_read(8'h2C);
        dstrb_read(8'h31);
        dstrb_read(8'h2B);
        req = "R7";
        dstrb_write(8'h40, 8'h12);
        dstrb_read(8'h40);

        // R8: split strobes ignored in data-strobe style
        req = "R8";
        addr_phase(8'h2D);
        ad_in = 8'h44; wr_n = 1'b0;
        repeat (4) step();
        wr_n = 1'b1; repeat (4) step();
        rd_n = 1'b0; repeat (4) step();
        rd_n = 1'b1; repeat (4) step();

        // R2: final readback of every register over the bus
        req = "R2";
        for (int k = 0; k < 8; k++) dstrb_read(8'h2B + k);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule